// File: doc/BRIEF.md
# Gray-Sequenced State Machine with Hop Checker

This block is a cyclic state machine that walks eight states in reflected Gray order, one step per cycle in which `advance` is high, and holds otherwise. Since a legal move alters at most one bit of the state code, a second register keeps the value the state had one clock earlier. The two are compared every cycle. If they differ in two or more bits, a sticky error flag is set, and it stays set until software-independent logic pulses `clear`.

The state register has spare guard bits above the Gray code. An explicit decoder checks the full register against the set of codes the sequence uses. Any value outside that set raises a one-cycle state error, and the next edge sends the machine home to code 000.

Two XOR mask inputs let a test environment flip chosen bits in the value loaded into each register. This models upsets. A flipped bit in the last-state register can raise the hop flag even though the state itself is correct. This false alarm is accepted behaviour.

Top module: `gray_watch_fsm`

## Requirements
- R1: `rst` is synchronous and active high. After a clock edge with `rst` high, `state_o` is 0, both flags are 0 and the last-state register is 0, so the first cycle after release raises no flag.
- R2: With `advance` high and a legal state, the edge moves `state_o[2:0]` along 000, 001, 011, 010, 110, 111, 101, 100 and back to 000. The guard bit `state_o[3]` stays 0.
- R3: With `advance` low and a legal state, `state_o` keeps its value across the edge.
- R4: Suppose that at an edge the state register and the last-state register differ in two or more bits. Then `trans_err_o` reads 1 after that edge. A difference of zero bits or one bit never sets it. A two-bit state upset is therefore flagged one edge after it lands, and a one-bit upset is not flagged.
- R5: The last-state register loads the current state at every non-reset edge, including hold cycles. A one-bit upset of it on a hold cycle therefore raises no flag and is gone one edge later.
- R6: The following upsets of the last-state register raise `trans_err_o` as a false alarm:
  - a two-bit upset;
  - a one-bit upset landing with a step that changes a different bit.
- R7: `trans_err_o` stays 1 until an edge at which `clear` is high and no new hop is detected. When `clear` and a new detection meet at the same edge, the flag stays 1.
- R8: A state outside the used set (any guard bit set, which at the defaults is `state_o[3]`) makes `state_err_o` read 1 after the next edge. That same edge loads 000 whatever `advance` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| advance | input | 1 | Step to the next Gray code when high |
| clear | input | 1 | Clears the sticky hop flag |
| upset_cur | input | SEQ_W+GUARD_W | XOR mask applied to the value loaded into the state register |
| upset_prev | input | SEQ_W+GUARD_W | XOR mask applied to the value loaded into the last-state register |
| state_o | output | SEQ_W+GUARD_W | Current state register |
| trans_err_o | output | 1 | Sticky flag for a hop of more than one bit |
| state_err_o | output | 1 | State held a code outside the used set in the previous cycle |

## Verification
A corrupted state register shows on `state_o` after the edge that loads the corruption. The hop flag follows one edge later, but only when two or more bits moved. A corrupted last-state register never shows on `state_o`. It appears only through `trans_err_o`, one edge after the corruption, and only when its difference from the state is two or more bits. A guard-bit corruption shows `state_err_o` high and `state_o` back at 000 one edge later, and the large jump home usually sets the hop flag on the edge after that.

// File: rtl/gfsm_pkg.sv
package gfsm_pkg;
  localparam int unsigned GFSM_MAX_W = 16;

  function automatic logic [GFSM_MAX_W-1:0] bin_to_gray(input logic [GFSM_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GFSM_MAX_W-1:0] gray_to_bin(input logic [GFSM_MAX_W-1:0] g);
    logic [GFSM_MAX_W-1:0] b;
    b[GFSM_MAX_W-1] = g[GFSM_MAX_W-1];
    for (int k = GFSM_MAX_W - 2; k >= 0; k--) begin
      b[k] = b[k+1] ^ g[k];
    end
    return b;
  endfunction
endpackage

// File: rtl/gfsm_legal_dec.sv
module gfsm_legal_dec #(
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned GUARD_W = 1
) (
  input  logic [SEQ_W+GUARD_W-1:0] cur,
  output logic                     legal
);
  localparam int unsigned REG_W = SEQ_W + GUARD_W;
  localparam int unsigned NUM_STATES = 1 << SEQ_W;

  logic [NUM_STATES-1:0] hit;

  // one comparator per used code; guard bits are part of every compare
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_code
    localparam int unsigned BIN = i;
    localparam logic [REG_W-1:0] CODE = REG_W'(BIN ^ (BIN >> 1));
    assign hit[i] = (cur == CODE);
  end

  assign legal = |hit;
endmodule

// File: rtl/gfsm_next.sv
module gfsm_next
  import gfsm_pkg::*;
#(
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned GUARD_W = 1
) (
  input  logic [SEQ_W+GUARD_W-1:0] cur,
  input  logic                     legal,
  input  logic                     advance,
  output logic [SEQ_W+GUARD_W-1:0] nxt
);
  localparam int unsigned REG_W = SEQ_W + GUARD_W;

  logic [SEQ_W-1:0] cur_bin;
  logic [SEQ_W-1:0] step_bin;
  logic [SEQ_W-1:0] step_gray;
  logic [GFSM_MAX_W-1:0] bin_wide;
  logic [GFSM_MAX_W-1:0] gray_wide;

  always_comb begin
    bin_wide  = gray_to_bin(GFSM_MAX_W'(cur[SEQ_W-1:0]));
    cur_bin   = bin_wide[SEQ_W-1:0];
    step_bin  = cur_bin + SEQ_W'(1);          // wraps to 0 after the last code
    gray_wide = bin_to_gray(GFSM_MAX_W'(step_bin));
    step_gray = gray_wide[SEQ_W-1:0];
    if (!legal) begin
      nxt = '0;                               // homing from an unused code
    end else if (advance) begin
      nxt = {{GUARD_W{1'b0}}, step_gray};
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/gfsm_hop_check.sv
module gfsm_hop_check #(
  parameter int unsigned REG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [REG_W-1:0] cur,
  input  logic [REG_W-1:0] prev,
  output logic             flag_o
);
  logic [REG_W-1:0] diff;
  logic             multi;
  logic             flag_q;

  // more than one bit set <=> clearing the lowest set bit leaves something
  assign diff  = cur ^ prev;
  assign multi = |(diff & (diff - REG_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= multi | (flag_q & ~clear);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gray_watch_fsm.sv
module gray_watch_fsm #(
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned GUARD_W = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     advance,
  input  logic                     clear,
  input  logic [SEQ_W+GUARD_W-1:0] upset_cur,
  input  logic [SEQ_W+GUARD_W-1:0] upset_prev,
  output logic [SEQ_W+GUARD_W-1:0] state_o,
  output logic                     trans_err_o,
  output logic                     state_err_o
);
  localparam int unsigned REG_W = SEQ_W + GUARD_W;

  logic [REG_W-1:0] cur_q;
  logic [REG_W-1:0] prev_q;
  logic [REG_W-1:0] nxt;
  logic             legal;
  logic             state_err_q;

  gfsm_legal_dec #(.SEQ_W(SEQ_W), .GUARD_W(GUARD_W)) u_dec (
    .cur   (cur_q),
    .legal (legal)
  );

  gfsm_next #(.SEQ_W(SEQ_W), .GUARD_W(GUARD_W)) u_next (
    .cur     (cur_q),
    .legal   (legal),
    .advance (advance),
    .nxt     (nxt)
  );

  gfsm_hop_check #(.REG_W(REG_W)) u_hop (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .cur    (cur_q),
    .prev   (prev_q),
    .flag_o (trans_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      prev_q      <= '0;
      state_err_q <= 1'b0;
    end else begin
      cur_q       <= nxt ^ upset_cur;
      prev_q      <= cur_q ^ upset_prev;   // reloaded every cycle, holds included
      state_err_q <= ~legal;
    end
  end

  assign state_o     = cur_q;
  assign state_err_o = state_err_q;
endmodule

// File: rtl/gray_watch_fsm_sva.sv
module gray_watch_fsm_sva #(
  parameter int unsigned SEQ_W   = 3,
  parameter int unsigned GUARD_W = 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     advance,
  input logic                     clear,
  input logic [SEQ_W+GUARD_W-1:0] upset_cur,
  input logic [SEQ_W+GUARD_W-1:0] upset_prev,
  input logic [SEQ_W+GUARD_W-1:0] state_o,
  input logic                     trans_err_o,
  input logic                     state_err_o,
  input logic [SEQ_W+GUARD_W-1:0] prev_q
);
  localparam int unsigned REG_W = SEQ_W + GUARD_W;

  logic guard_set;
  assign guard_set = |state_o[REG_W-1:SEQ_W];

  assert_reset_home_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_o == '0 && !trans_err_o && !state_err_o));

  assert_step_one_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && !guard_set && upset_cur == '0) |=> ($countones(state_o ^ $past(state_o)) == 1));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (!advance && !guard_set && upset_cur == '0) |=> $stable(state_o));

  assert_multi_hop_sets_R4: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_o ^ prev_q) > 1) |=> trans_err_o);

  assert_single_hop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!trans_err_o && $countones(state_o ^ prev_q) <= 1) |=> !trans_err_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (trans_err_o && !clear) |=> trans_err_o);

  assert_unused_code_homes_R8: assert property (@(posedge clk) disable iff (rst)
    (guard_set && upset_cur == '0) |=> (state_o == '0 && state_err_o));
endmodule

bind gray_watch_fsm gray_watch_fsm_sva #(.SEQ_W(SEQ_W), .GUARD_W(GUARD_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .advance     (advance),
  .clear       (clear),
  .upset_cur   (upset_cur),
  .upset_prev  (upset_prev),
  .state_o     (state_o),
  .trans_err_o (trans_err_o),
  .state_err_o (state_err_o),
  .prev_q      (prev_q)
);

// File: tb/gray_watch_fsm_tb.sv
`timescale 1ns/1ps
module gray_watch_fsm_tb;
  localparam int unsigned W = 4;
  localparam int unsigned NV = 30;
  localparam int unsigned WATCHDOG_NS = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         advance = 1'b0;
  logic         clear = 1'b0;
  logic [W-1:0] upset_cur = '0;
  logic [W-1:0] upset_prev = '0;
  logic [W-1:0] state_o;
  logic         trans_err_o;
  logic         state_err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gray_watch_fsm u_dut (
    .clk         (clk),
    .rst         (rst),
    .advance     (advance),
    .clear       (clear),
    .upset_cur   (upset_cur),
    .upset_prev  (upset_prev),
    .state_o     (state_o),
    .trans_err_o (trans_err_o),
    .state_err_o (state_err_o)
  );

  // {adv, clr, upset_cur[3:0], upset_prev[3:0], exp_state[3:0], exp_trans, exp_state_err}
  localparam logic [15:0] VEC [NV] = '{
    16'b1_0_0000_0000_0001_0_0, // R2 000->001, no flag on first cycle
    16'b1_0_0000_0000_0011_0_0, // R2
    16'b0_0_0000_0000_0011_0_0, // R3 hold
    16'b1_0_0000_0000_0010_0_0, // R2
    16'b1_0_0000_0000_0110_0_0, // R2
    16'b1_0_0000_0000_0111_0_0, // R2
    16'b1_0_0000_0000_0101_0_0, // R2
    16'b1_0_0000_0000_0100_0_0, // R2
    16'b1_0_0000_0000_0000_0_0, // R2 wrap
    16'b0_0_0001_0000_0001_0_0, // R4 one-bit state upset lands
    16'b0_0_0000_0000_0001_0_0, // R4 not flagged
    16'b0_0_0110_0000_0111_0_0, // R4 two-bit state upset lands
    16'b0_0_0000_0000_0111_1_0, // R4 flagged one edge later
    16'b0_1_0000_0000_0111_0_0, // R7 clear
    16'b0_0_0000_0001_0111_0_0, // R5 one-bit last-state upset
    16'b0_0_0000_0000_0111_0_0, // R5 no flag, reloaded
    16'b0_0_0000_0011_0111_0_0, // R6 two-bit last-state upset
    16'b0_0_0000_0000_0111_1_0, // R6 false alarm
    16'b0_1_0000_0000_0111_0_0, // R7 clear
    16'b1_0_0000_0100_0101_0_0, // R6 step bit1 with last-state bit2 flipped
    16'b0_0_0000_0000_0101_1_0, // R6 false alarm
    16'b0_1_0000_0000_0101_0_0, // R7 clear
    16'b0_0_1000_0000_1101_0_0, // R8 guard bit set
    16'b1_0_0000_0000_0000_0_1, // R8 homed, state error
    16'b0_0_0000_0000_0000_1_0, // R8 jump home flagged as hop
    16'b1_1_0000_0000_0001_0_0, // R7 clear
    16'b0_0_0110_0000_0111_0_0, // R4 two-bit upset
    16'b0_1_0000_0000_0111_1_0, // R7 set wins over clear
    16'b0_0_0000_0000_0111_1_0, // R7 sticky
    16'b0_1_0000_0000_0111_0_0  // R7 clear
  };

  function automatic string req_of(input int i);
    if (i == 2) return "R3";
    if (i < 9) return "R2";
    if (i < 13) return "R4";
    if (i == 13 || i == 18 || i == 21 || i >= 25) return "R7";
    if (i < 16) return "R5";
    if (i < 21) return "R6";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [W-1:0] es, input logic et, input logic ee);
    checks++;
    if (state_o !== es || trans_err_o !== et || state_err_o !== ee) begin
      errors++;
      $display("FAIL %s: state=%b trans=%b serr=%b expected state=%b trans=%b serr=%b",
               req, state_o, trans_err_o, state_err_o, es, et, ee);
    end
  endtask

  // called at a negedge; drives inputs, then waits through one rising edge
  task automatic apply(input logic a, input logic c, input logic [W-1:0] uc, input logic [W-1:0] up);
    advance = a; clear = c; upset_cur = uc; upset_prev = up;
    @(negedge clk);
  endtask

  initial begin
    #(WATCHDOG_NS);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);          // in reset
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15], VEC[i][14], VEC[i][13:10], VEC[i][9:6]);
      check(req_of(i), VEC[i][5:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset with the flag set clears both registers and the flags
    apply(0, 0, 4'b0110, 4'b0000);
    check("R4", 4'b0001, 1'b0, 1'b0);
    apply(0, 0, 4'b0000, 4'b0000);
    check("R4", 4'b0001, 1'b1, 1'b0);
    rst = 1'b1;
    apply(1, 0, 4'b0000, 4'b0000);
    check("R1", 4'b0000, 1'b0, 1'b0);
    rst = 1'b0;
    apply(1, 0, 4'b0000, 4'b0000);
    check("R1", 4'b0001, 1'b0, 1'b0);          // last-state was zeroed

    // R8: homing happens with advance low as well
    apply(0, 0, 4'b1000, 4'b0000);
    check("R8", 4'b1001, 1'b0, 1'b0);
    apply(0, 0, 4'b0000, 4'b0000);
    check("R8", 4'b0000, 1'b0, 1'b1);
    apply(0, 0, 4'b0000, 4'b0000);
    check("R8", 4'b0000, 1'b1, 1'b0);          // 1001 -> 0000 is a two-bit hop

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule